// File: doc/BRIEF.md
# Stored-Input Parallel-to-Serial Shifter

This block serializes a parallel word through two independently clocked stages. A capture register takes a snapshot of the parallel input on every rising edge of its own clock. A shift register, running on a second clock, moves data toward its top bit, and that top bit drives the serial output. The shift register can be refilled from the captured word at any moment through an active-low, level-sensitive, asynchronous load.

An active-low asynchronous reset clears only the shift register. The capture register is untouched by that reset and has its own synchronous active-high clear, so simulation can start from a known state. Driving load and reset low together is an illegal combination. The block resolves it in favour of reset and reports it on a flag while it lasts. Typical use is to latch a word on one clock domain, transfer it with a load pulse, and then stream it out MSB first on the shift clock. The serial input lets several of these blocks be chained.

Top module: `stored_shifter`

## Requirements
- R1: On each rising edge of `store_clk_i` the capture register takes `par_i`, or takes all zeros when `store_clr_i` is 1 at that edge. Neither `rst_ni` nor `load_ni` affects it.
- R2: With `load_ni`=1 and `rst_ni`=1, each rising edge of `shift_clk_i` moves bit n-1 into bit n and `ser_i` into bit 0.
- R3: `ser_o` always shows bit WIDTH-1, the MSB, of the shift register, so a word leaves MSB first.
- R4: While `load_ni`=0 and `rst_ni`=1, the shift register equals the captured word without any clock edge. This includes a word captured while the load is still held low.
- R5: While `rst_ni`=0 and `load_ni`=1, the shift register reads all zeros without any clock edge. The captured word survives and can be loaded after the reset is released.
- R6: A `shift_clk_i` edge that occurs while `load_ni`=0 or `rst_ni`=0 causes no shift.
- R7: `illegal_o` is 1 exactly while `load_ni`=0 and `rst_ni`=0. During that time reset wins and the shift register reads zero.
- R8: After the illegal case, a valid clear or load restores a defined shift register content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| store_clk_i | input | 1 | Capture register clock |
| store_clr_i | input | 1 | Synchronous active-high clear of the capture register |
| par_i | input | WIDTH | Parallel data input |
| shift_clk_i | input | 1 | Shift register clock |
| rst_ni | input | 1 | Asynchronous active-low clear of the shift register |
| load_ni | input | 1 | Asynchronous active-low load from the capture register |
| ser_i | input | 1 | Serial data into bit 0 |
| ser_o | output | 1 | Serial data out, the MSB of the shift register |
| illegal_o | output | 1 | High while load and reset are both asserted |

## Verification
The bench builds the block with WIDTH=4. At that width all 16 words can be swept through both the parallel load path and the serial fill path, and every word is read back bit by bit at the serial output. The narrow width also keeps the tests of asynchronous follow, reset isolation, ignored shift edges and the illegal combination short, so each test can be repeated over every word rather than a handful.

// File: rtl/stored_shifter_pkg.sv
package stored_shifter_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT   = 2'b00,
    MODE_LOAD    = 2'b01,
    MODE_CLEAR   = 2'b10,
    MODE_ILLEGAL = 2'b11
  } ctrl_mode_e;
endpackage

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (clr_i) q_o <= '0;
    else       q_o <= d_i;
  end
endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import stored_shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] stored_i,
  output logic [WIDTH-1:0] set_o,
  output logic [WIDTH-1:0] clr_o,
  output ctrl_mode_e       mode_o,
  output logic             illegal_o
);
  always_comb begin
    unique case ({~rst_ni, ~load_ni})
      2'b00:   mode_o = MODE_SHIFT;
      2'b01:   mode_o = MODE_LOAD;
      2'b10:   mode_o = MODE_CLEAR;
      default: mode_o = MODE_ILLEGAL;
    endcase
  end

  assign illegal_o = (mode_o == MODE_ILLEGAL);

  // reset takes priority: set only acts in pure load mode
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      set_o[i] = (mode_o == MODE_LOAD) &  stored_i[i];
      clr_o[i] = (mode_o == MODE_CLEAR) || (mode_o == MODE_ILLEGAL) ||
                 ((mode_o == MODE_LOAD) & ~stored_i[i]);
    end
  end
endmodule

// File: rtl/shift_cell.sv
module shift_cell (
  input  logic clk_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  // async set/clear flop; clear dominates
  always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/stored_shifter.sv
module stored_shifter
  import stored_shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             store_clk_i,
  input  logic             store_clr_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             shift_clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             ser_i,
  output logic             ser_o,
  output logic             illegal_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] shift_d;
  logic [WIDTH-1:0] set_v;
  logic [WIDTH-1:0] clr_v;
  ctrl_mode_e       mode;

  capture_reg #(.WIDTH(WIDTH)) u_capture (
    .clk_i (store_clk_i),
    .clr_i (store_clr_i),
    .d_i   (par_i),
    .q_o   (store_q)
  );

  ctrl_decode #(.WIDTH(WIDTH)) u_decode (
    .rst_ni    (rst_ni),
    .load_ni   (load_ni),
    .stored_i  (store_q),
    .set_o     (set_v),
    .clr_o     (clr_v),
    .mode_o    (mode),
    .illegal_o (illegal_o)
  );

  assign shift_d = {shift_q[MSB-1:0], ser_i};

  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    shift_cell u_cell (
      .clk_i (shift_clk_i),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .d_i   (shift_d[g]),
      .q_o   (shift_q[g])
    );
  end

  assign ser_o = shift_q[MSB];
endmodule

// File: rtl/stored_shifter_chk.sv
module stored_shifter_chk #(
  parameter int WIDTH = 8
) (
  input logic             store_clk_i,
  input logic             store_clr_i,
  input logic [WIDTH-1:0] par_i,
  input logic             shift_clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic             illegal_o,
  input logic             ser_o,
  input logic [WIDTH-1:0] store_q,
  input logic [WIDTH-1:0] shift_q
);
  logic seen_q = 1'b0;
  always_ff @(posedge store_clk_i) seen_q <= 1'b1;

  // R1
  capture_tracks_input_chk: assert property (
    @(posedge store_clk_i) disable iff (store_clr_i)
    (seen_q && !$past(store_clr_i)) |-> (store_q == $past(par_i)));

  // R4
  load_follows_store_chk: assert property (
    @(posedge store_clk_i) disable iff (!rst_ni)
    !load_ni |-> (shift_q == store_q));

  // R6
  shift_blocked_by_load_chk: assert property (
    @(posedge shift_clk_i) disable iff (!rst_ni)
    !load_ni |-> (shift_q == store_q));

  // R5
  reset_zeroes_shifter_chk: assert property (
    @(posedge shift_clk_i) disable iff (load_ni)
    !rst_ni |-> (shift_q == '0));

  // R7
  illegal_reset_wins_chk: assert property (
    @(posedge shift_clk_i) disable iff (rst_ni)
    illegal_o |-> (shift_q == '0 && !ser_o));
endmodule

bind stored_shifter stored_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .store_clk_i (store_clk_i),
  .store_clr_i (store_clr_i),
  .par_i       (par_i),
  .shift_clk_i (shift_clk_i),
  .rst_ni      (rst_ni),
  .load_ni     (load_ni),
  .illegal_o   (illegal_o),
  .ser_o       (ser_o),
  .store_q     (store_q),
  .shift_q     (shift_q)
);

// File: tb/sim_stored_shifter.sv
module sim_stored_shifter;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic store_clk = 1'b0, store_clr = 1'b0, shift_clk = 1'b0;
  logic rst_n = 1'b1, load_n = 1'b1, ser_in = 1'b0;
  logic [W-1:0] par = '0;
  logic ser_out, illegal;
  int checks = 0, fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  stored_shifter #(.WIDTH(W)) u0 (
    .store_clk_i (store_clk), .store_clr_i (store_clr), .par_i (par),
    .shift_clk_i (shift_clk), .rst_ni (rst_n), .load_ni (load_n),
    .ser_i (ser_in), .ser_o (ser_out), .illegal_o (illegal)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic store_pulse(input logic [W-1:0] v);
    par = v; #3 store_clk = 1'b1; #5 store_clk = 1'b0; #2;
  endtask

  task automatic shift_pulse(input logic b);
    ser_in = b; #3 shift_clk = 1'b1; #5 shift_clk = 1'b0; #2;
  endtask

  task automatic do_load();
    #2 load_n = 1'b0; #4 load_n = 1'b1; #2;
  endtask

  // reads the shifter MSB first; zeros are shifted in behind
  task automatic read_word(input string req, input logic [W-1:0] exp);
    for (int i = W - 1; i >= 0; i--) begin
      #1 chk(req, ser_out, exp[i]);
      shift_pulse(1'b0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    // reset state
    store_clr = 1'b1; store_pulse('0); store_clr = 1'b0;
    rst_n = 1'b0; #5;
    chk("R5 reset ser_o", ser_out, 1'b0);
    chk("R7 no illegal", illegal, 1'b0);
    rst_n = 1'b1; #5;

    // R1 R3: parallel path over every word
    for (int v = 0; v < N; v++) begin
      store_pulse(W'(v));
      do_load();
      read_word("R1 R3 load/readout", W'(v));
    end

    // R2: serial fill over every word
    for (int v = 0; v < N; v++) begin
      rst_n = 1'b0; #2 rst_n = 1'b1; #2;
      for (int i = W - 1; i >= 0; i--) shift_pulse(v[i]);
      read_word("R2 serial fill", W'(v));
    end

    // R4: follow while load held low, including new captures
    for (int v = 0; v < N; v++) begin
      load_n = 1'b0; #2;
      store_pulse(W'(v));
      #1 chk("R4 follow msb", ser_out, v[W-1]);
      store_pulse(W'(~v));
      #1 chk("R4 follow new msb", ser_out, ~v[W-1]);
      load_n = 1'b1; #2;
      read_word("R4 follow content", W'(~v));
    end

    // R5: reset clears shifter only
    for (int v = 1; v < N; v++) begin
      store_pulse(W'(v)); do_load();
      rst_n = 1'b0; #2;
      chk("R5 cleared", ser_out, 1'b0);
      store_pulse(W'(v)); // capture during reset still works (R1)
      rst_n = 1'b1; #2;
      read_word("R5 zeros after clear", '0);
      do_load();
      read_word("R5 storage kept", W'(v));
    end

    // R6: shift edges ignored under load or reset
    for (int v = 0; v < N; v++) begin
      store_pulse(W'(v));
      load_n = 1'b0; #2;
      shift_pulse(1'b1); shift_pulse(1'b0);
      load_n = 1'b1; #2;
      read_word("R6 no shift under load", W'(v));
      rst_n = 1'b0; #2;
      shift_pulse(1'b1);
      rst_n = 1'b1; #2;
      read_word("R6 no shift under reset", '0);
    end

    // R7 R8: illegal combination
    for (int v = 0; v < N; v++) begin
      store_pulse(W'(v));
      rst_n = 1'b0; load_n = 1'b0; #3;
      chk("R7 flag high", illegal, 1'b1);
      chk("R7 reset wins", ser_out, 1'b0);
      load_n = 1'b1; #2;
      chk("R7 flag low", illegal, 1'b0);
      rst_n = 1'b1; #2;
      read_word("R8 clear recovers", '0);
      rst_n = 1'b0; load_n = 1'b0; #3;
      rst_n = 1'b1; #2;
      chk("R8 flag off", illegal, 1'b0);
      load_n = 1'b1; #2;
      do_load();
      read_word("R8 load recovers", W'(v));
    end

    // R1: synchronous clear of the capture register
    store_pulse(W'(N - 1));
    store_clr = 1'b1; store_pulse(W'(N - 1)); store_clr = 1'b0;
    do_load();
    read_word("R1 capture clear", '0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule